// File: doc/BRIEF.md
# SMBus Word-Register Slave

This block is a serial slave on a two-wire SMBus. It oversamples SCL and SDA with the system clock and pulls SDA low through an open-drain enable. After a start condition it takes in a device-address byte and compares it with a fixed 7-bit address. When the address matches, the next byte selects one register. The block then moves 16-bit words between the bus and a small internal register file. On the bus, the low byte of each word goes first and the high byte second, and each byte is sent most significant bit first.

To write, the master sends the address with the write flag, the register number, the low data byte and the high data byte, and then a stop. To read, the master sends the address with the write flag and the register number. It then issues a repeated start and the address with the read flag, and the slave returns the low byte and then the high byte. The master acknowledges the low byte, refuses the high byte, and ends with a stop. A read that starts directly with a read address uses the last register number that was selected. The register file holds four words at register numbers 0x14, 0x15, 0x3F and 0xFE, and all four reset to zero.

Top module: `smbus_word_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) is recognized in any state, including partway through a byte. It discards any partial byte and begins a new address byte. The open-drain enable is low in the cycle after the start.
- R2: When the first byte after a start carries device address 7'b0001001 in bits 7:1, the slave drives SDA low for the ninth clock. Bit 0 of that byte selects the direction: 0 is write and 1 is read.
- R3: When the address bits do not match, SDA stays released on the ninth clock and on every later clock until the next start. The master therefore sees no acknowledge for that byte or for any byte after it, even a byte that carries the correct address.
- R4: In a write, the slave acknowledges the register-number byte, the low data byte and the high data byte.
- R5: A write changes the selected register only once the high byte has been acknowledged. A stop that comes after only the low byte leaves the register unchanged.
- R6: A read (address+W, register number, repeated start, address+R) returns bits 7:0 of the register first and bits 15:8 second, each sent MSB first.
- R7: The open-drain enable is low after reset and whenever the bus is idle after a stop. After the master refuses the final read byte, the slave releases SDA before the next SCL rising edge.
- R8: A write to a register number outside {0x14, 0x15, 0x3F, 0xFE} is acknowledged on every byte and then discarded. A read from such a number returns 0x0000.
- R9: The open-drain enable changes from released to driving only while SCL is low.
- R10: Each of the four register numbers selects its own 16-bit storage word. A write to one register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
The hardest cases to reach from the ports are the broken frames: a start that arrives in the middle of a byte, a write that stops after only the low byte, and bytes that follow an address the slave does not answer. Each of these needs bit-level control of the bus, so the bench drives SCL and SDA through small tasks that can stop after any number of bits, insert a repeated start, or end early with a stop. The bench then reads the affected register back over the bus to show that no stray value was written. A seeded random mix of word writes and reads, covering both implemented and unimplemented register numbers, is checked against a model of the four registers kept in the bench.

// File: rtl/smbus_word_pkg.sv
package smbus_word_pkg;

    localparam int NREG   = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Register numbers that select real storage; entry i maps to word i.
    localparam logic [NREG*BYTE_W-1:0] REG_NUM_LIST = {8'hFE, 8'h3F, 8'h15, 8'h14};

    // Index of the byte being framed after a start; saturates at the last value.
    localparam int BIDX_W          = 3;
    localparam logic [BIDX_W-1:0] BIDX_DEV  = 3'd0;
    localparam logic [BIDX_W-1:0] BIDX_REG  = 3'd1;
    localparam logic [BIDX_W-1:0] BIDX_LO   = 3'd2;
    localparam logic [BIDX_W-1:0] BIDX_HI   = 3'd3;
    localparam logic [BIDX_W-1:0] BIDX_XTRA = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_TX,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        bus_state_e          st;
        logic [3:0]          bit_cnt;
        logic [BIDX_W-1:0]   bidx;
        logic                is_read;
        logic                ack_pend;
        logic                tx_second;
        logic                oe;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   tx_hi;
        logic [BYTE_W-1:0]   lo;
        logic [BYTE_W-1:0]   ptr;
    } slave_state_t;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    // Both bus lines rest high, so the flops reset high to avoid a false edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '1;
            end
            prev_q <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/smbus_cond_detect.sv
module smbus_cond_detect (
    input  logic scl_lvl_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o
);

    // SDA may change while SCL is high only to frame a transfer.
    assign start_o = scl_lvl_i & sda_fall_i;
    assign stop_o  = scl_lvl_i & sda_rise_i;

endmodule

// File: rtl/smbus_word_regfile.sv
module smbus_word_regfile
    import smbus_word_pkg::*;
#(
    parameter int                      N      = NREG,
    parameter int                      AW     = BYTE_W,
    parameter int                      DW     = WORD_W,
    parameter logic [N*AW-1:0]         NUMS   = REG_NUM_LIST
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] num_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [N-1:0]  hit_o
);

    logic [DW-1:0] word_d [N];
    logic [DW-1:0] word_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign hit_o[g] = (num_i == NUMS[g*AW +: AW]);

        always_comb begin
            word_d[g] = word_q[g];
            if (wr_en_i && hit_o[g]) begin
                word_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d[g];
            end
        end
    end

    // A number that matches no slot reads as zero.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_o[i]) begin
                rdata_o = rdata_o | word_q[i];
            end
        end
    end

endmodule

// File: rtl/smbus_word_slave.sv
module smbus_word_slave
    import smbus_word_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;
    localparam logic [3:0] LAST_DATA_BIT = 4'd7;
    localparam logic [3:0] ACK_SLOT      = 4'd8;

    logic [1:0] lvl, rise, fall;
    logic       scl_s, sda_s, scl_rise, scl_fall;
    logic       start, stop;

    smbus_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_s    = lvl[LN_SCL];
    assign sda_s    = lvl[LN_SDA];
    assign scl_rise = rise[LN_SCL];
    assign scl_fall = fall[LN_SCL];

    smbus_cond_detect u_cond (
        .scl_lvl_i  (scl_s),
        .sda_rise_i (rise[LN_SDA]),
        .sda_fall_i (fall[LN_SDA]),
        .start_o    (start),
        .stop_o     (stop)
    );

    slave_state_t        cur_q, nxt_d;
    logic                wr_en;
    logic [WORD_W-1:0]   rd_word;
    logic [NREG-1:0]     rf_hit;
    logic [BYTE_W-1:0]   byte_in;
    bus_state_e          st_q;

    smbus_word_regfile u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .num_i   (cur_q.ptr),
        .wr_en_i (wr_en),
        .wdata_i ({cur_q.shreg, cur_q.lo}),
        .rdata_o (rd_word),
        .hit_o   (rf_hit)
    );

    assign byte_in = {cur_q.shreg[BYTE_W-2:0], sda_s};
    assign st_q    = cur_q.st;

    always_comb begin
        nxt_d = cur_q;
        wr_en = 1'b0;
        if (start) begin
            nxt_d.st        = ST_RX;
            nxt_d.bit_cnt   = '0;
            nxt_d.bidx      = BIDX_DEV;
            nxt_d.is_read   = 1'b0;
            nxt_d.ack_pend  = 1'b0;
            nxt_d.tx_second = 1'b0;
            nxt_d.oe        = 1'b0;
        end else if (stop) begin
            nxt_d.st       = ST_IDLE;
            nxt_d.bit_cnt  = '0;
            nxt_d.ack_pend = 1'b0;
            nxt_d.oe       = 1'b0;
        end else begin
            unique case (cur_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        if (cur_q.bit_cnt != ACK_SLOT) begin
                            nxt_d.shreg   = byte_in;
                            nxt_d.bit_cnt = cur_q.bit_cnt + 4'd1;
                            if (cur_q.bit_cnt == LAST_DATA_BIT) begin
                                nxt_d.ack_pend = 1'b1;
                                if (cur_q.bidx == BIDX_DEV) begin
                                    if (byte_in[BYTE_W-1:1] == DEV_ADDR) begin
                                        nxt_d.is_read = byte_in[0];
                                    end else begin
                                        nxt_d.st       = ST_SKIP;
                                        nxt_d.ack_pend = 1'b0;
                                    end
                                end else if (cur_q.bidx == BIDX_REG) begin
                                    nxt_d.ptr = byte_in;
                                end else if (cur_q.bidx == BIDX_LO) begin
                                    nxt_d.lo = byte_in;
                                end
                            end
                        end else begin
                            // Ninth clock: the acknowledge has been seen by the master.
                            nxt_d.bit_cnt  = '0;
                            nxt_d.ack_pend = 1'b0;
                            if (cur_q.bidx != BIDX_XTRA) begin
                                nxt_d.bidx = cur_q.bidx + 1'b1;
                            end
                            if (cur_q.bidx == BIDX_DEV && cur_q.is_read) begin
                                nxt_d.st        = ST_TX;
                                nxt_d.shreg     = rd_word[BYTE_W-1:0];
                                nxt_d.tx_hi     = rd_word[WORD_W-1:BYTE_W];
                                nxt_d.tx_second = 1'b0;
                            end
                            if (cur_q.bidx == BIDX_HI) begin
                                wr_en = 1'b1;
                            end
                        end
                    end else if (scl_fall) begin
                        nxt_d.oe = (cur_q.bit_cnt == ACK_SLOT) && cur_q.ack_pend;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (cur_q.bit_cnt != ACK_SLOT) begin
                            nxt_d.shreg   = {cur_q.shreg[BYTE_W-2:0], 1'b0};
                            nxt_d.bit_cnt = cur_q.bit_cnt + 4'd1;
                        end else begin
                            nxt_d.bit_cnt = '0;
                            if (!sda_s && !cur_q.tx_second) begin
                                nxt_d.shreg     = cur_q.tx_hi;
                                nxt_d.tx_second = 1'b1;
                            end else begin
                                nxt_d.st = ST_SKIP;
                            end
                        end
                    end else if (scl_fall) begin
                        nxt_d.oe = (cur_q.bit_cnt != ACK_SLOT) && !cur_q.shreg[BYTE_W-1];
                    end
                end
                default: begin
                    nxt_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{st: ST_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_oe_o = cur_q.oe;

endmodule

// File: rtl/smbus_word_slave_chk.sv
module smbus_word_slave_chk
    import smbus_word_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic            scl_lvl,
    input logic            start,
    input logic            stop,
    input logic            sda_oe_o,
    input bus_state_e      st_q,
    input logic            wr_en,
    input logic [NREG-1:0] rf_hit
);

    assert_start_reframe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (st_q == ST_RX) && !sda_oe_o);

    assert_stop_to_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop |=> (st_q == ST_IDLE) && !sda_oe_o);

    assert_idle_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_IDLE) |-> !sda_oe_o);

    assert_skip_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_SKIP) |-> !sda_oe_o);

    assert_commit_during_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> sda_oe_o);

    assert_drive_on_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> !scl_lvl);

    assert_single_slot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rf_hit));

endmodule

bind smbus_word_slave smbus_word_slave_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_lvl  (scl_s),
    .start    (start),
    .stop     (stop),
    .sda_oe_o (sda_oe_o),
    .st_q     (st_q),
    .wr_en    (wr_en),
    .rf_hit   (rf_hit)
);

// File: tb/smbus_word_slave_tb.sv
module smbus_word_slave_tb;

    localparam int         Q   = 10;
    localparam logic [6:0] DEV = 7'b0001001;
    localparam logic [7:0] AW  = {DEV, 1'b0};
    localparam logic [7:0] AR  = {DEV, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    smbus_word_slave u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;
    logic [15:0] model [4];

    always @(negedge clk) begin
        if (sda_oe && !oe_prev && scl) r9_viol++;
        oe_prev = sda_oe;
    end

    function automatic int slot_of(logic [7:0] n);
        case (n)
            8'h14: return 0;
            8'h15: return 1;
            8'h3F: return 2;
            8'hFE: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] expect_word(logic [7:0] n);
        int s = slot_of(n);
        return (s < 0) ? 16'h0000 : model[s];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl = 1'b0; hold(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hold(Q);
        scl = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bit(logic b);
        sda_m = b; hold(Q);
        scl = 1'b1; hold(2 * Q);
        scl = 1'b0; hold(Q);
    endtask

    task automatic write_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(Q);
        scl = 1'b1; hold(Q);
        acked = ~sda_line;
        hold(Q);
        scl = 1'b0; hold(Q);
    endtask

    task automatic read_byte(logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            scl = 1'b1; hold(Q);
            b[i] = sda_line;
            hold(Q);
            scl = 1'b0; hold(Q);
        end
        sda_m = ~mack; hold(Q);
        scl = 1'b1; hold(2 * Q);
        scl = 1'b0; hold(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(logic [7:0] n, logic [15:0] w, string tag);
        logic a0, a1, a2, a3;
        bus_start();
        write_byte(AW, a0);
        write_byte(n, a1);
        write_byte(w[7:0], a2);
        write_byte(w[15:8], a3);
        bus_stop();
        chk({tag, " write acks"}, {a0, a1, a2, a3}, 4'b1111);
        if (slot_of(n) >= 0) model[slot_of(n)] = w;
    endtask

    task automatic do_read(logic [7:0] n, output logic [15:0] w);
        logic a0, a1, a2;
        bus_start();
        write_byte(AW, a0);
        write_byte(n, a1);
        bus_rstart();
        write_byte(AR, a2);
        read_byte(1'b1, w[7:0]);
        read_byte(1'b0, w[15:8]);
        chk("R7 released after final NACK", sda_oe, 1'b0);
        bus_stop();
        chk("R2 R4 read acks", {a0, a1, a2}, 3'b111);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        logic        a;
        for (int i = 0; i < 4; i++) model[i] = 16'h0000;
        void'($urandom(32'h5eed_0731));
        hold(5);
        chk("R7 enable low in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        hold(10);
        chk("R7 enable low after reset", sda_oe, 1'b0);

        // R2 R4 R6: basic word write then word read
        do_write(8'h14, 16'hABCD, "R4");
        do_read(8'h14, w);
        chk("R6 low byte first", w, 16'hABCD);
        chk("R7 idle after stop", sda_oe, 1'b0);

        // R10: each register keeps its own word
        do_write(8'h15, 16'h1111, "R10");
        do_write(8'h3F, 16'h8001, "R10");
        do_write(8'hFE, 16'h00FF, "R10");
        do_read(8'h14, w); chk("R10 slot 0x14", w, 16'hABCD);
        do_read(8'h15, w); chk("R10 slot 0x15", w, 16'h1111);
        do_read(8'h3F, w); chk("R10 slot 0x3F", w, 16'h8001);
        do_read(8'hFE, w); chk("R10 slot 0xFE", w, 16'h00FF);

        // R3: wrong address, then later bytes including the correct address
        bus_start();
        write_byte({7'h12, 1'b0}, a); chk("R3 wrong address NACK", a, 1'b0);
        write_byte(8'h14, a);         chk("R3 ignored register byte", a, 1'b0);
        write_byte(AW, a);            chk("R3 own address without start", a, 1'b0);
        write_byte(8'h55, a);         chk("R3 ignored data byte", a, 1'b0);
        bus_stop();
        do_read(8'h14, w); chk("R3 register untouched", w, 16'hABCD);

        // R5: stop after only the low byte
        bus_start();
        write_byte(AW, a);
        write_byte(8'h15, a);
        write_byte(8'h55, a); chk("R5 low byte acked", a, 1'b1);
        bus_stop();
        do_read(8'h15, w); chk("R5 aborted write discarded", w, 16'h1111);

        // R1: start in the middle of an address byte
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_rstart();
        write_byte(AW, a);      chk("R1 address after mid-byte start", a, 1'b1);
        write_byte(8'h3F, a);
        write_byte(8'h34, a);
        write_byte(8'h12, a);   chk("R1 high byte acked", a, 1'b1);
        bus_stop();
        model[2] = 16'h1234;
        do_read(8'h3F, w); chk("R1 write after reframe", w, 16'h1234);

        // R1: start in the middle of a data byte discards it
        bus_start();
        write_byte(AW, a);
        write_byte(8'hFE, a);
        write_byte(8'hAA, a);
        send_bit(1'b0); send_bit(1'b1);
        bus_rstart();
        write_byte({7'h40, 1'b0}, a); chk("R1 new frame decodes address", a, 1'b0);
        bus_stop();
        do_read(8'hFE, w); chk("R1 partial data discarded", w, 16'h00FF);

        // R8: unimplemented register numbers
        do_write(8'h20, 16'hDEAD, "R8");
        do_read(8'h20, w); chk("R8 unimplemented reads zero", w, 16'h0000);
        do_read(8'h14, w); chk("R8 write not aliased", w, 16'hABCD);

        // Seeded random mix checked against the model
        for (int k = 0; k < 30; k++) begin
            logic [7:0] n;
            logic [15:0] d;
            int pick = $urandom % 5;
            n = (pick == 0) ? 8'h14 : (pick == 1) ? 8'h15 : (pick == 2) ? 8'h3F :
                (pick == 3) ? 8'hFE : 8'($urandom);
            d = 16'($urandom);
            if ($urandom % 2 == 0) begin
                do_write(n, d, (slot_of(n) < 0) ? "R8" : "R4");
            end else begin
                do_read(n, w);
                chk((slot_of(n) < 0) ? "R8 random read" : "R10 random read", w, expect_word(n));
            end
        end

        chk("R9 drive begins only with SCL low", r9_viol, 0);
        finish_run();
    end

endmodule